// File: doc/BRIEF.md
# Packed narrow transfer sequencer

This block sits between a 32-bit debug data register and a single-beat memory port. Each debug access names a transfer size of 8, 16, 32 or 64 bits and an addressing mode. The block turns that access into one or more memory transfers. Every transfer is one beat long, and only one is outstanding at a time.

In packed mode a narrow size splits the 32-bit debug word into several narrow transfers at consecutive addresses. The byte lane of each transfer follows from its address. Lanes are used starting at the lane of the base address and wrap around past lane 3. Read beats fill the same lanes of the returned word. The sequence ends early when a beat returns an error or when the debug side aborts. The block also reports the address the debug side should use for its next access.

Top module: `packed_xfer_seq`

## Requirements
- R1: Every issued transfer has length field 0000, burst type 00 and lock 00. Once a beat is accepted (`sys_valid` and `sys_ready` both high), `sys_valid` stays low until that beat's response.
- R2: Size code 000 is byte, 001 is halfword, 010 is word, 011 is doubleword, and 1xx is treated as word. Each beat address has its low bits below the transfer size forced to zero. For example, a halfword at 0x01 goes to 0x00 and a doubleword at 0x0C goes to 0x08.
- R3: Mode code 10 is packed. It issues 4 beats for bytes, 2 for halfwords and 1 for word or doubleword. Modes 00 (no increment), 01 (single increment) and 11 (treated as 00) issue exactly one beat.
- R4: `sys_wdata` carries the whole debug word, and `sys_strb` marks the lanes a beat uses. A byte at address a uses lane a[1:0]. A halfword uses lanes 1:0 when a[1] is 0 and lanes 3:2 when a[1] is 1. Word and doubleword beats use all four lanes.
- R5: In packed mode beat k goes to the aligned base plus k times the size in bytes. The lanes therefore wrap: a packed byte write at 0x2 goes to 0x2, 0x3, 0x4, 0x5 on lanes 2, 3, 0, 1.
- R6: The read result holds, on each issued beat's lanes, the returned data of those lanes. All lanes that no beat used read as zero.
- R7: `dbg_ready` is a one-cycle pulse in the cycle after the last beat's response. The read data, error flag and next address are valid in that cycle.
- R8: A beat response with `sys_err` high ends the sequence after that beat. `dbg_err` is the OR of the error flags of all issued beats.
- R9: `req_abort` seen while a beat is pending ends the sequence after that beat. An abort while idle is ignored.
- R10: `dbg_next_addr` equals the address of the last issued beat plus the size in bytes for modes 01 and 10. It equals the unmodified request address for modes 00 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Debug access request, one-cycle pulse while idle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 3 | Transfer size code |
| req_mode | input | 2 | Addressing mode code |
| req_addr | input | AW | Base address |
| req_wdata | input | 32 | Debug write word |
| req_abort | input | 1 | Abort request |
| dbg_ready | output | 1 | Access complete pulse |
| dbg_rdata | output | 32 | Assembled read word |
| dbg_err | output | 1 | OR of beat errors |
| dbg_next_addr | output | AW | Address for the following access |
| sys_valid | output | 1 | Beat request valid |
| sys_ready | input | 1 | Beat request accepted |
| sys_write | output | 1 | Beat direction |
| sys_addr | output | AW | Beat address |
| sys_size | output | 3 | Beat size code |
| sys_len | output | 4 | Burst length field |
| sys_burst | output | 2 | Burst type field |
| sys_lock | output | 2 | Lock field |
| sys_strb | output | 4 | Lanes used by the beat |
| sys_wdata | output | 32 | Beat write data |
| sys_done | input | 1 | Beat response valid |
| sys_err | input | 1 | Beat response error |
| sys_rdata | input | 32 | Beat read data |

## Verification
The assertions assume that a request pulse arrives only while the block is idle. They also assume that the memory side returns exactly one response per accepted beat, and only after the acceptance. The bench memory model grants a beat on the cycle it is requested and answers one cycle later. It never raises a response without an accepted beat. The bench starts a new access only after the previous ready pulse. Errors and aborts are injected only on chosen beats of a live sequence, and one abort is also issued while idle.

// File: rtl/packed_xfer_seq.sv
module packed_xfer_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [2:0]    req_size,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  input  logic          req_abort,
  output logic          dbg_ready,
  output logic [31:0]   dbg_rdata,
  output logic          dbg_err,
  output logic [AW-1:0] dbg_next_addr,
  output logic          sys_valid,
  input  logic          sys_ready,
  output logic          sys_write,
  output logic [AW-1:0] sys_addr,
  output logic [2:0]    sys_size,
  output logic [3:0]    sys_len,
  output logic [1:0]    sys_burst,
  output logic [1:0]    sys_lock,
  output logic [3:0]    sys_strb,
  output logic [31:0]   sys_wdata,
  input  logic          sys_done,
  input  logic          sys_err,
  input  logic [31:0]   sys_rdata
);

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_ADDR = 2'd1;
  localparam logic [1:0] S_RESP = 2'd2;
  localparam logic [1:0] S_DONE = 2'd3;

  logic [1:0]    st;
  logic          wr_r;
  logic [2:0]    size_r;
  logic [1:0]    mode_r;
  logic [AW-1:0] base_r, cur_addr, next_r;
  logic [31:0]   wdata_r, rd_acc;
  logic [1:0]    left;
  logic          err_acc, abort_seen;

  function automatic logic [3:0] size_bytes(input logic [2:0] s);
    return s[2] ? 4'd4 : (4'd1 << s[1:0]);
  endfunction

  logic [3:0] req_bytes, cur_bytes;
  logic [1:0] req_beats;
  logic       stop_now, incr_mode;
  logic [31:0] lane_mask;

  assign req_bytes = size_bytes(req_size);
  assign cur_bytes = size_bytes(size_r);
  assign req_beats = (req_mode != 2'b10) ? 2'd0 :
                     (req_size == 3'b000) ? 2'd3 :
                     (req_size == 3'b001) ? 2'd1 : 2'd0;
  assign incr_mode = (mode_r == 2'b01) || (mode_r == 2'b10);
  assign stop_now  = sys_err || abort_seen || req_abort || (left == 2'd0);

  always_comb begin
    case (size_r)
      3'b000:  sys_strb = 4'b0001 << cur_addr[1:0];
      3'b001:  sys_strb = cur_addr[1] ? 4'b1100 : 4'b0011;
      default: sys_strb = 4'b1111;
    endcase
  end

  assign lane_mask = {{8{sys_strb[3]}}, {8{sys_strb[2]}},
                      {8{sys_strb[1]}}, {8{sys_strb[0]}}};

  assign sys_valid     = (st == S_ADDR);
  assign sys_write     = wr_r;
  assign sys_addr      = cur_addr;
  assign sys_size      = size_r;
  assign sys_len       = 4'b0000;
  assign sys_burst     = 2'b00;
  assign sys_lock      = 2'b00;
  assign sys_wdata     = wdata_r;
  assign dbg_ready     = (st == S_DONE);
  assign dbg_rdata     = rd_acc;
  assign dbg_err       = err_acc;
  assign dbg_next_addr = next_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      wr_r       <= 1'b0;
      size_r     <= 3'b010;
      mode_r     <= 2'b00;
      base_r     <= '0;
      cur_addr   <= '0;
      next_r     <= '0;
      wdata_r    <= '0;
      rd_acc     <= '0;
      left       <= '0;
      err_acc    <= 1'b0;
      abort_seen <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            st         <= S_ADDR;
            wr_r       <= req_write;
            size_r     <= req_size;
            mode_r     <= req_mode;
            base_r     <= req_addr;
            cur_addr   <= req_addr & ~AW'(req_bytes - 4'd1);
            wdata_r    <= req_wdata;
            rd_acc     <= '0;
            left       <= req_beats;
            err_acc    <= 1'b0;
            abort_seen <= 1'b0;
          end
        end
        S_ADDR: begin
          if (req_abort) abort_seen <= 1'b1;
          if (sys_ready) st <= S_RESP;
        end
        S_RESP: begin
          if (req_abort) abort_seen <= 1'b1;
          if (sys_done) begin
            err_acc <= err_acc | sys_err;
            if (!wr_r) rd_acc <= rd_acc | (sys_rdata & lane_mask);
            if (stop_now) begin
              st     <= S_DONE;
              next_r <= incr_mode ? cur_addr + AW'(cur_bytes) : base_r;
            end else begin
              st       <= S_ADDR;
              cur_addr <= cur_addr + AW'(cur_bytes);
              left     <= left - 2'd1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_valid && sys_ready) |=> !sys_valid);

  // R2
  aligned_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_valid |-> ((sys_addr & AW'(size_bytes(sys_size) - 4'd1)) == '0));

  // R4
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_valid && sys_size == 3'b000) |-> ($countones(sys_strb) == 1));

  // R7
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ready |=> !dbg_ready);

  // R7
  ready_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_ready |-> $past(sys_done));

  // R8
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RESP && sys_done && sys_err) |=> (dbg_ready && dbg_err));

  // R9
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RESP && sys_done && (abort_seen || req_abort)) |=> dbg_ready);

endmodule

// File: tb/packed_xfer_seq_test.sv
module packed_xfer_seq_test;
  localparam int AW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_abort = 0;
  logic [2:0] req_size = 0;
  logic [1:0] req_mode = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic dbg_ready, dbg_err, sys_valid, sys_write;
  logic [31:0] dbg_rdata, sys_wdata;
  logic [AW-1:0] dbg_next_addr, sys_addr;
  logic [2:0] sys_size;
  logic [3:0] sys_len, sys_strb;
  logic [1:0] sys_burst, sys_lock;
  logic sys_ready = 0, sys_done = 0, sys_err = 0;
  logic [31:0] sys_rdata = 0;

  packed_xfer_seq #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_mode(req_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_abort(req_abort), .dbg_ready(dbg_ready),
    .dbg_rdata(dbg_rdata), .dbg_err(dbg_err), .dbg_next_addr(dbg_next_addr),
    .sys_valid(sys_valid), .sys_ready(sys_ready), .sys_write(sys_write),
    .sys_addr(sys_addr), .sys_size(sys_size), .sys_len(sys_len),
    .sys_burst(sys_burst), .sys_lock(sys_lock), .sys_strb(sys_strb),
    .sys_wdata(sys_wdata), .sys_done(sys_done), .sys_err(sys_err),
    .sys_rdata(sys_rdata));

  always #10 clk = ~clk;

  typedef struct packed { logic [AW-1:0] a; logic [2:0] sz; logic [3:0] strb; logic w; } beat_t;
  typedef struct packed { logic [31:0] rd; logic e; logic [AW-1:0] nx; } res_t;
  beat_t beat_q[$];
  res_t  res_q[$];

  int n_chk = 0, n_fail = 0, err_beat = -1, abort_beat = -1, bidx = 0, done_cnt = 0;
  logic [31:0] exp_wd;

  function automatic logic [31:0] rd_word(input logic [AW-1:0] a);
    return 32'hC3A55A3C ^ {4{a[7:0]}};
  endfunction

  function automatic logic [3:0] strb_of(input logic [2:0] s, input logic [AW-1:0] a);
    if (s == 3'b000) return 4'b0001 << a[1:0];
    if (s == 3'b001) return a[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model and monitor
  int ph = 0;
  logic [AW-1:0] pend_a;
  always @(negedge clk) begin
    if (rst_n) begin
      if (ph == 1) begin
        sys_ready <= 0; req_abort <= 0;
        sys_done <= 1; sys_rdata <= rd_word(pend_a); sys_err <= (bidx == err_beat);
        bidx++;
        ph = 2;
      end else begin
        sys_done <= 0; sys_err <= 0;
        ph = 0;
        if (sys_valid) begin
          beat_t e;
          if (beat_q.size() == 0) chk(0, "R3 extra beat", 64'(sys_addr), 0);
          else begin
            e = beat_q.pop_front();
            chk(sys_addr == e.a, "R2 R5 beat address", 64'(sys_addr), 64'(e.a));
            chk(sys_strb == e.strb, "R4 strobe", 64'(sys_strb), 64'(e.strb));
            chk(sys_size == e.sz && sys_write == e.w, "R3 size/dir", 64'({sys_size, sys_write}), 64'({e.sz, e.w}));
            if (e.w) chk(sys_wdata == exp_wd, "R4 write data", 64'(sys_wdata), 64'(exp_wd));
          end
          chk(sys_len == 0 && sys_burst == 0 && sys_lock == 0, "R1 single beat fields",
              64'({sys_len, sys_burst, sys_lock}), 0);
          pend_a = sys_addr;
          sys_ready <= 1;
          if (bidx == abort_beat) req_abort <= 1;
          ph = 1;
        end
      end
      if (dbg_ready) begin
        res_t r;
        chk(beat_q.size() == 0, "R3 R8 R9 beats left at ready", 64'(beat_q.size()), 0);
        beat_q.delete();
        if (res_q.size() == 0) chk(0, "R7 unexpected ready", 1, 0);
        else begin
          r = res_q.pop_front();
          chk(dbg_rdata == r.rd, "R6 read data", 64'(dbg_rdata), 64'(r.rd));
          chk(dbg_err == r.e, "R8 error flag", 64'(dbg_err), 64'(r.e));
          chk(dbg_next_addr == r.nx, "R10 next address", 64'(dbg_next_addr), 64'(r.nx));
        end
        bidx = 0;
        done_cnt++;
      end
    end
  end

  task automatic run(input logic w, input logic [2:0] sz, input logic [1:0] md,
                     input logic [AW-1:0] a, input logic [31:0] wd, input int eb, input int ab);
    int by, nb, start;
    logic [AW-1:0] ba, cur;
    res_t r;
    by = sz[2] ? 4 : (1 << sz[1:0]);
    nb = (md != 2'b10) ? 1 : (sz == 3'b000) ? 4 : (sz == 3'b001) ? 2 : 1;
    ba = a & ~AW'(by - 1);
    r = '0;
    cur = ba;
    for (int i = 0; i < nb; i++) begin
      cur = ba + AW'(i * by);
      beat_q.push_back('{a: cur, sz: sz, strb: strb_of(sz, cur), w: w});
      if (!w) r.rd |= rd_word(cur) & {{8{strb_of(sz, cur)[3]}}, {8{strb_of(sz, cur)[2]}},
                                       {8{strb_of(sz, cur)[1]}}, {8{strb_of(sz, cur)[0]}}};
      if (i == eb) r.e = 1;
      if (i == eb || i == ab) break;
    end
    r.nx = (md == 2'b01 || md == 2'b10) ? cur + AW'(by) : a;
    res_q.push_back(r);
    err_beat = eb; abort_beat = ab; exp_wd = wd;
    start = done_cnt;
    @(negedge clk);
    req_valid <= 1; req_write <= w; req_size <= sz; req_mode <= md;
    req_addr <= a; req_wdata <= wd;
    @(negedge clk);
    req_valid <= 0;
    while (done_cnt == start) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!dbg_ready && !sys_valid, "R7 reset idle", 64'({dbg_ready, sys_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    // R9 abort while idle is ignored: no beat, no ready
    req_abort <= 1; @(negedge clk); req_abort <= 0;
    repeat (3) @(negedge clk);
    chk(!sys_valid && !dbg_ready, "R9 idle abort ignored", 64'({sys_valid, dbg_ready}), 0);
    run(1, 3'b000, 2'b01, 32'h2, 32'hA1B2C3D4, -1, -1);   // R4 unpacked byte write
    run(0, 3'b000, 2'b01, 32'h1, 0, -1, -1);              // R6 unpacked byte read
    run(1, 3'b001, 2'b00, 32'h1, 32'h11223344, -1, -1);   // R2 R10 no increment
    run(1, 3'b000, 2'b10, 32'h2, 32'h55667788, -1, -1);   // R5 packed byte write wrap
    run(0, 3'b001, 2'b10, 32'h2, 0, -1, -1);              // R5 R6 packed half read
    run(0, 3'b000, 2'b10, 32'h11, 0, -1, -1);             // R6 packed byte read
    run(0, 3'b010, 2'b10, 32'h13, 0, -1, -1);             // R3 word packed single beat
    run(1, 3'b011, 2'b01, 32'h0C, 32'hDEADBEEF, -1, -1);  // R2 doubleword
    run(1, 3'b000, 2'b10, 32'h40, 32'h01020304, 1, -1);   // R8 error mid sequence
    run(0, 3'b001, 2'b10, 32'h20, 0, -1, 0);              // R9 abort first beat
    run(0, 3'b000, 2'b10, 32'h33, 0, 3, -1);              // R8 error last beat
    run(0, 3'b001, 2'b11, 32'h6, 0, -1, -1);              // R3 R10 mode 11
    run(1, 3'b110, 2'b10, 32'h7, 32'hCAFEF00D, -1, -1);   // R2 size 1xx as word
    chk(res_q.size() == 0, "R7 all results seen", 64'(res_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule